// File: doc/BRIEF.md
# Multidrop 9-bit Serial Station Receiver

This block is the station end of a shared serial line on which one controller talks to several stations. Every frame has nine payload bits. The last of them, the flag bit, tells whether the eight bits before it are a station code (flag 1) or ordinary payload (flag 0). A station starts in listening mode. In that mode it drops every payload frame without raising an interrupt, and it compares the code of each address frame with its own `station_code_i`.

When the codes match, the station leaves listening mode. It reports the code with a receive pulse and then hands every later payload frame to the host with a receive pulse. If it then sees an address frame with a different code, it returns to listening mode. The host can also force the station back into listening mode. A small transmitter lets only the selected station send a 9-bit frame back to the controller.

One shared clock-enable divider paces both directions. Each bit lasts 16 enable ticks, and the receiver samples each bit near its middle.

Top module: `mdrop_uart_slave`

## Requirements
- R1: A received frame is a low start bit, then 8 code bits sent least significant bit first, then the flag bit, then a high stop bit. Each bit lasts 16·CLK_DIV clocks. The line idles high.
- R2: After reset, `wake_o` is 1, `txd_o` is 1, `tx_busy_o` is 0, and `rx_irq_o` and `frame_err_o` are 0.
- R3: While `wake_o` is 1, a frame with flag 0 raises no `rx_irq_o`, leaves `rx_data_o` unchanged and leaves `wake_o` at 1.
- R4: An address frame (flag 1) whose code equals `station_code_i` clears `wake_o` to 0. It also pulses `rx_irq_o` with `rx_data_o` equal to the code and `rx_addr_o` equal to 1.
- R5: An address frame whose code differs from `station_code_i` raises no `rx_irq_o` and leaves `wake_o` at 1. This holds whether the station was listening or selected before the frame.
- R6: While `wake_o` is 0, every frame with flag 0 pulses `rx_irq_o` with its 8 code bits on `rx_data_o` and `rx_addr_o` equal to 0.
- R7: A low pulse on `rxd_i` that is high again by the middle of the start bit starts no frame. It causes no pulse on `rx_irq_o` or `frame_err_o`.
- R8: A frame whose stop bit reads 0 pulses `frame_err_o` and is discarded: no `rx_irq_o`, and `wake_o` is unchanged.
- R9: A pulse on `wake_set_i` sets `wake_o` to 1.
- R10: `tx_load_i`, accepted while `wake_o` is 0 and `tx_busy_o` is 0, sends a frame on `txd_o` in this order: start 0, `tx_data_i` least significant bit first, `tx_b8_i`, stop 1. Each bit lasts 16·CLK_DIV clocks. `tx_busy_o` stays 1 from the cycle after the load until the stop bit ends.
- R11: `tx_load_i` has no effect while `wake_o` is 1 or `tx_busy_o` is 1.
- R12: `rx_irq_o` and `frame_err_o` are single-cycle pulses, with exactly one pulse per qualifying frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| station_code_i | input | 8 | Code this station answers to |
| wake_set_i | input | 1 | Puts the station back into listening mode |
| rxd_i | input | 1 | Serial receive line |
| rx_data_o | output | 8 | Last delivered code bits |
| rx_addr_o | output | 1 | Flag bit of the last delivered frame |
| rx_irq_o | output | 1 | Receive pulse |
| frame_err_o | output | 1 | Pulse when a stop bit reads low |
| wake_o | output | 1 | 1 while the station is listening for its code |
| tx_load_i | input | 1 | Starts a transmit frame |
| tx_data_i | input | 8 | Transmit code bits |
| tx_b8_i | input | 1 | Transmit flag bit |
| txd_o | output | 1 | Serial transmit line |
| tx_busy_o | output | 1 | 1 while a frame is being sent |

## Verification
A wrong listening flag shows up at the ports within one frame time. Either a payload frame that should be dropped raises a receive pulse, or the station stays silent after its own code. The flag is also visible on `wake_o` one clock after the stop-bit sample. A mis-stepped bit counter or an off-centre sample point shifts or corrupts the delivered code, so the full sweep of all 256 address codes exposes it on the first frame affected. A transmitter shift error appears on `txd_o` within 16 enable ticks of the bit it corrupts.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int OVS      = 16;
  localparam int CODE_W   = 8;
  localparam int PAY_W    = CODE_W + 1;
  localparam int TXF_W    = PAY_W + 2;
  localparam int OVS_W    = $clog2(OVS);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  typedef struct packed {
    logic              flag;
    logic [CODE_W-1:0] code;
  } frame_t;
endpackage

// File: rtl/mdrop_baud_tick.sv
module mdrop_baud_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (cnt_q == CW'(CLK_DIV - 1)) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
  import mdrop_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   rxd_i,
  output logic   done_o,
  output logic   ferr_o,
  output frame_t frame_o
);
  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        st_q;
  logic [OVS_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [PAY_W-1:0] sr_q;

  assign rx_s    = sync_q[1];
  assign frame_o = frame_t'(sr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
      done_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: if (!rx_s) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            if (cnt_q == OVS_W'(OVS/2 - 1)) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rx_s ? RX_IDLE : RX_BITS;  // glitch rejection
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_BITS: begin
            if (cnt_q == OVS_W'(OVS - 1)) begin
              cnt_q <= '0;
              sr_q  <= {rx_s, sr_q[PAY_W-1:1]};
              if (idx_q == 4'(PAY_W - 1)) st_q <= RX_STOP;
              else                        idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == OVS_W'(OVS - 1)) begin
              cnt_q  <= '0;
              done_o <= 1'b1;
              ferr_o <= !rx_s;
              st_q   <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdrop_wake_filter.sv
module mdrop_wake_filter
  import mdrop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              ferr_i,
  input  frame_t            frame_i,
  input  logic [CODE_W-1:0] station_code_i,
  input  logic              wake_set_i,
  output logic [CODE_W-1:0] rx_data_o,
  output logic              rx_addr_o,
  output logic              rx_irq_o,
  output logic              frame_err_o,
  output logic              wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o   <= '0;
      rx_addr_o   <= 1'b0;
      rx_irq_o    <= 1'b0;
      frame_err_o <= 1'b0;
      wake_o      <= 1'b1;
    end else begin
      rx_irq_o    <= 1'b0;
      frame_err_o <= 1'b0;
      if (done_i) begin
        if (ferr_i) begin
          frame_err_o <= 1'b1;
        end else if (frame_i.flag) begin
          if (frame_i.code == station_code_i) begin
            wake_o    <= 1'b0;
            rx_irq_o  <= 1'b1;
            rx_data_o <= frame_i.code;
            rx_addr_o <= 1'b1;
          end else begin
            wake_o    <= 1'b1;
          end
        end else if (!wake_o) begin
          rx_irq_o  <= 1'b1;
          rx_data_o <= frame_i.code;
          rx_addr_o <= 1'b0;
        end
      end else if (wake_set_i) begin
        wake_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdrop_tx_frame.sv
module mdrop_tx_frame
  import mdrop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              flag_i,
  output logic              txd_o,
  output logic              busy_o
);
  logic [TXF_W-1:0] sr_q;
  logic [OVS_W-1:0] cnt_q;
  logic [3:0]       nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      nb_q   <= '0;
      busy_o <= 1'b0;
    end else if (!busy_o) begin
      if (load_i) begin
        sr_q   <= {1'b1, flag_i, data_i, 1'b0};
        cnt_q  <= '0;
        nb_q   <= '0;
        busy_o <= 1'b1;
      end
    end else if (tick_i) begin
      if (cnt_q == OVS_W'(OVS - 1)) begin
        cnt_q <= '0;
        sr_q  <= {1'b1, sr_q[TXF_W-1:1]};
        if (nb_q == 4'(TXF_W - 1)) busy_o <= 1'b0;
        else                       nb_q   <= nb_q + 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign txd_o = busy_o ? sr_q[0] : 1'b1;
endmodule

// File: rtl/mdrop_uart_slave.sv
module mdrop_uart_slave
  import mdrop_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] station_code_i,
  input  logic       wake_set_i,
  input  logic       rxd_i,
  output logic [7:0] rx_data_o,
  output logic       rx_addr_o,
  output logic       rx_irq_o,
  output logic       frame_err_o,
  output logic       wake_o,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_b8_i,
  output logic       txd_o,
  output logic       tx_busy_o
);
  logic   tick;
  logic   rx_done;
  logic   rx_ferr;
  frame_t rx_frame;

  mdrop_baud_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  mdrop_rx_frame u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .ferr_o (rx_ferr),
    .frame_o(rx_frame)
  );

  mdrop_wake_filter u_wake (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_i        (rx_done),
    .ferr_i        (rx_ferr),
    .frame_i       (rx_frame),
    .station_code_i(station_code_i),
    .wake_set_i    (wake_set_i),
    .rx_data_o     (rx_data_o),
    .rx_addr_o     (rx_addr_o),
    .rx_irq_o      (rx_irq_o),
    .frame_err_o   (frame_err_o),
    .wake_o        (wake_o)
  );

  // only the selected station may answer
  mdrop_tx_frame u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .load_i(tx_load_i & ~wake_o),
    .data_i(tx_data_i),
    .flag_i(tx_b8_i),
    .txd_o (txd_o),
    .busy_o(tx_busy_o)
  );
endmodule

// File: rtl/mdrop_uart_slave_chk.sv
module mdrop_uart_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] station_code_i,
  input logic       wake_o,
  input logic       rx_irq_o,
  input logic       rx_addr_o,
  input logic [7:0] rx_data_o,
  input logic       frame_err_o,
  input logic       tx_load_i,
  input logic       tx_busy_o,
  input logic       txd_o
);
  // R12
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);
  // R12
  ferr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);
  // R4
  select_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_o) |-> (rx_irq_o && rx_addr_o && rx_data_o == station_code_i));
  // R3
  data_only_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && !rx_addr_o) |-> !wake_o);
  // R8
  ferr_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !rx_irq_o);
  // R11
  tx_start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> ($past(tx_load_i) && !$past(wake_o)));
  // R2
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> txd_o);
endmodule

bind mdrop_uart_slave mdrop_uart_slave_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .station_code_i(station_code_i),
  .wake_o        (wake_o),
  .rx_irq_o      (rx_irq_o),
  .rx_addr_o     (rx_addr_o),
  .rx_data_o     (rx_data_o),
  .frame_err_o   (frame_err_o),
  .tx_load_i     (tx_load_i),
  .tx_busy_o     (tx_busy_o),
  .txd_o         (txd_o)
);

// File: tb/sim_mdrop_uart_slave.sv
module sim_mdrop_uart_slave;
  localparam int DIV = 1;
  localparam int BITC = 16 * DIV;
  localparam logic [7:0] STN = 8'h0A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] stn = STN;
  logic wake_set = 1'b0, rxd = 1'b1, tx_load = 1'b0, tx_b8 = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic rx_addr, rx_irq, ferr, wake, txd, tx_busy;

  int n_run = 0, n_fail = 0;
  int irq_cnt = 0, ferr_cnt = 0;
  logic [7:0] got_data = '0;
  logic got_addr = 1'b0;

  always #5 clk = ~clk;

  mdrop_uart_slave #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .station_code_i(stn), .wake_set_i(wake_set),
    .rxd_i(rxd), .rx_data_o(rx_data), .rx_addr_o(rx_addr), .rx_irq_o(rx_irq),
    .frame_err_o(ferr), .wake_o(wake), .tx_load_i(tx_load), .tx_data_i(tx_data),
    .tx_b8_i(tx_b8), .txd_o(txd), .tx_busy_o(tx_busy)
  );

  always @(negedge clk) begin
    if (rx_irq) begin
      irq_cnt++;
      got_data = rx_data;
      got_addr = rx_addr;
    end
    if (ferr) ferr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic flag, input logic stopb);
    logic [10:0] f;
    f = {stopb, flag, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk) rxd = f[i];
      repeat (BITC - 1) @(negedge clk);
    end
    @(negedge clk) rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c0, f0;
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(wake == 1'b1, "R2 wake", wake, 1);
    chk(txd == 1'b1, "R2 txd", txd, 1);
    chk(tx_busy == 1'b0, "R2 busy", tx_busy, 0);
    chk(!rx_irq && !ferr, "R2 pulses", rx_irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 data frames dropped while listening
    for (int k = 0; k < 8; k++) begin
      c0 = irq_cnt; d0 = rx_data;
      send(8'(k * 37 + 5), 1'b0, 1'b1);
      chk(irq_cnt == c0, "R3 no irq", irq_cnt - c0, 0);
      chk(rx_data == d0 && wake, "R3 data/wake kept", rx_data, d0);
    end

    // R11 load ignored while listening
    @(negedge clk) begin tx_load = 1'b1; tx_data = 8'h55; end
    @(negedge clk) tx_load = 1'b0;
    chk(!tx_busy && txd, "R11 load while listening", tx_busy, 0);

    // R4 R5 R12 R1 sweep of every address code
    for (int code = 0; code < 256; code++) begin
      c0 = irq_cnt;
      send(8'(code), 1'b1, 1'b1);
      if (code == STN) begin
        chk(irq_cnt == c0 + 1, "R4/R12 irq count", irq_cnt - c0, 1);
        chk(got_data == STN && got_addr, "R4 R1 code", got_data, STN);
        chk(!wake, "R4 wake cleared", wake, 0);
      end else begin
        chk(irq_cnt == c0, "R5 no irq", irq_cnt - c0, 0);
        chk(wake, "R5 wake set", wake, 1);
      end
    end

    // select, then deliver data frames
    send(STN, 1'b1, 1'b1);
    for (int k = 0; k < 16; k++) begin
      c0 = irq_cnt;
      send(8'(k * 29 + 3), 1'b0, 1'b1);
      chk(irq_cnt == c0 + 1, "R6 R12 irq", irq_cnt - c0, 1);
      chk(got_data == 8'(k * 29 + 3) && !got_addr, "R6 R1 data", got_data, k * 29 + 3);
    end

    // R7 start glitch
    c0 = irq_cnt; f0 = ferr_cnt;
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BITC) @(negedge clk);
    chk(irq_cnt == c0 && ferr_cnt == f0, "R7 glitch ignored", irq_cnt - c0, 0);

    // R8 framing error, selected station stays selected
    c0 = irq_cnt; f0 = ferr_cnt;
    send(8'hC3, 1'b0, 1'b0);
    chk(ferr_cnt == f0 + 1, "R8 R12 ferr pulse", ferr_cnt - f0, 1);
    chk(irq_cnt == c0 && !wake, "R8 discarded", irq_cnt - c0, 0);

    // R10 transmit while selected
    for (int k = 0; k < 3; k++) begin
      logic [10:0] ef;
      logic [7:0] td;
      logic tb;
      td = 8'(k * 91 + 17); tb = k[0];
      ef = {1'b1, tb, td, 1'b0};
      @(negedge clk) begin tx_load = 1'b1; tx_data = td; tx_b8 = tb; end
      @(negedge clk) tx_load = 1'b0;
      chk(tx_busy, "R10 busy", tx_busy, 1);
      repeat (7) @(negedge clk);
      for (int i = 0; i < 11; i++) begin
        chk(txd == ef[i], "R10 tx bit", txd, ef[i]);
        if (i == 4) begin
          // R11 load while busy ignored
          tx_load = 1'b1; tx_data = 8'hFF;
          @(negedge clk) tx_load = 1'b0;
          repeat (BITC - 1) @(negedge clk);
        end else repeat (BITC) @(negedge clk);
      end
      repeat (BITC) @(negedge clk);
      chk(!tx_busy && txd, "R10 R11 idle after frame", tx_busy, 0);
    end

    // R5 other code drops selection
    c0 = irq_cnt;
    send(8'h01, 1'b1, 1'b1);
    chk(wake && irq_cnt == c0, "R5 deselect", wake, 1);

    // R9 wake_set
    send(STN, 1'b1, 1'b1);
    chk(!wake, "R9 precondition", wake, 0);
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
    chk(wake, "R9 wake set", wake, 1);
    c0 = irq_cnt;
    send(8'h44, 1'b0, 1'b1);
    chk(irq_cnt == c0, "R9 R3 data dropped", irq_cnt - c0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule